// File: doc/BRIEF.md
# Table-Assisted Modular Fine Reducer

This block takes an unsigned value that an upstream arithmetic chain has left only loosely reduced and returns its residue modulo a fixed odd modulus q. Earlier adders and subtractors are allowed to let additive error build up, so an operand may hold any value below 512·q. The reducer runs once at the end of that chain instead of after every operation.

The top bits of the operand address a table of multiples of q, and that table is computed during elaboration. The selected multiple is subtracted from the operand. One or two conditional subtractions of q then finish the job. The block is fully pipelined: it accepts one operand per clock, and each result appears a fixed number of cycles later with its own valid flag. The operand width, the modulus width, the modulus and the width of the table index are parameters.

Top module: `fine_reducer`

## Requirements
- R1: The operand is Q_W+9 bits wide. Every operand presented with in_valid high lies in [0, 512·q).
- R2: For every accepted operand x, the result is x mod q, and it therefore lies in [0, q).
- R3: Each result appears exactly 3 clock edges after its operand is sampled. Back-to-back operands produce back-to-back results, one per cycle.
- R4: out_valid equals in_valid delayed by 3 clock edges, so idle gaps in the input reappear unchanged at the output.
- R5: A cycle with in_valid low loads nothing into the pipeline. In the matching output cycle out_valid is low and out_residue keeps its previous value.
- R6: While rst is high, and after reset until the first result arrives, out_valid is 0 and out_residue is 0.
- R7: Table entry i holds the largest multiple of q not greater than i·2^S, where S is the operand width minus IDX_W. The table is built at elaboration. As a result, exact multiples of q, q−1, q and 512·q−1 all reduce correctly.
- R8: IDX_W may be 9 or 10. With 10 index bits one conditional subtraction of q follows the table step; with 9 index bits two follow. Both variants give identical results. q must be odd with its top bit (bit Q_W−1) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand qualifier |
| in_value | input | Q_W+9 | Loosely reduced operand, below 512·q |
| out_valid | output | 1 | Result qualifier |
| out_residue | output | Q_W | Operand modulo q |

## Verification
Every result is due on the third rising edge after its operand is sampled. The bench drives on the falling edge and keeps a three-deep history of what it drove. On each falling edge it compares both outputs against the entry driven three falling edges earlier. A valid entry must come back as its remainder modulo q. An idle entry must come back with out_valid low and the residue unchanged from the previous sample. Two instances, one for each index width, see the same stimulus: the boundary values, every multiple of q with idle gaps between them, a full back-to-back sweep of the whole input range, and random operands with random gaps.

// File: rtl/fr_pkg.sv
package fr_pkg;

    // Span of accumulated error, in powers of two of q (512 multiples).
    localparam int unsigned FR_SPAN_BITS = 9;

    // Largest multiple of q that does not exceed idx * 2^shift.
    function automatic longint unsigned fr_entry(longint unsigned idx,
                                                 int unsigned shift,
                                                 longint unsigned q);
        longint unsigned base;
        base = idx << shift;
        return (base / q) * q;
    endfunction

    // Number of trailing conditional subtractions a given index width needs.
    function automatic int unsigned fr_fix_count(int unsigned idx_w);
        return (idx_w >= 10) ? 1 : 2;
    endfunction

endpackage

// File: rtl/fr_mult_rom.sv
module fr_mult_rom #(
    parameter int unsigned IDX_W = 9,
    parameter int unsigned SHIFT = 8,
    parameter int unsigned Q     = 251,
    parameter int unsigned D_W   = 10
) (
    input  logic [IDX_W-1:0] idx,
    output logic [D_W-1:0]   mult
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [D_W-1:0] tbl [DEPTH];

    // Only the low D_W bits are kept: the subtraction that consumes them
    // yields a difference that always fits in D_W bits.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam longint unsigned ENT = fr_pkg::fr_entry(longint'(i), SHIFT, longint'(Q));
        assign tbl[i] = ENT[D_W-1:0];
    end

    assign mult = tbl[idx];
endmodule

// File: rtl/fr_fixup.sv
module fr_fixup #(
    parameter int unsigned Q_W     = 8,
    parameter int unsigned Q       = 251,
    parameter int unsigned D_W     = 10,
    parameter int unsigned NUM_FIX = 2
) (
    input  logic [D_W-1:0] resid,
    output logic [Q_W-1:0] reduced
);
    localparam logic [D_W-1:0] Q_D = D_W'(Q);
    localparam logic [Q_W-1:0] Q_N = Q_W'(Q);

    logic [D_W-1:0] chain [NUM_FIX];

    assign chain[0] = resid;

    // All but the last correction keep the full width.
    for (genvar j = 0; j + 1 < NUM_FIX; j++) begin : g_fix
        assign chain[j+1] = (chain[j] >= Q_D) ? (chain[j] - Q_D) : chain[j];
    end

    // Final correction: the result is below q, so Q_W bits suffice.
    assign reduced = (chain[NUM_FIX-1] >= Q_D) ? (chain[NUM_FIX-1][Q_W-1:0] - Q_N)
                                               : chain[NUM_FIX-1][Q_W-1:0];
endmodule

// File: rtl/fine_reducer.sv
module fine_reducer
    import fr_pkg::*;
#(
    parameter int unsigned Q_W   = 8,
    parameter int unsigned Q     = 251,
    parameter int unsigned IDX_W = 9,
    localparam int unsigned IN_W = Q_W + FR_SPAN_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_value,
    output logic            out_valid,
    output logic [Q_W-1:0]  out_residue
);
    localparam int unsigned SHIFT   = IN_W - IDX_W;
    localparam int unsigned D_W     = Q_W + 2;
    localparam int unsigned NUM_FIX = fr_fix_count(IDX_W);

    if (IDX_W != 9 && IDX_W != 10) begin : g_bad_idx
        $error("fine_reducer: IDX_W must be 9 or 10");
    end
    if ((Q % 2) == 0 || Q < (1 << (Q_W - 1)) || Q >= (1 << Q_W)) begin : g_bad_q
        $error("fine_reducer: Q must be odd with bit Q_W-1 set");
    end

    typedef struct packed {
        logic           a_vld;
        logic [D_W-1:0] a_val;
        logic [D_W-1:0] a_mul;
        logic           b_vld;
        logic [D_W-1:0] b_res;
        logic           o_vld;
        logic [Q_W-1:0] o_res;
    } pipe_t;

    pipe_t          st_d, st_q;
    logic [D_W-1:0] rom_mul;
    logic [D_W-1:0] diff_lo;
    logic [Q_W-1:0] fixed_res;

    fr_mult_rom #(
        .IDX_W (IDX_W),
        .SHIFT (SHIFT),
        .Q     (Q),
        .D_W   (D_W)
    ) u_rom (
        .idx  (in_value[IN_W-1 -: IDX_W]),
        .mult (rom_mul)
    );

    // True difference is below 3q < 2^D_W, so low-bit arithmetic is exact.
    assign diff_lo = st_q.a_val - st_q.a_mul;

    fr_fixup #(
        .Q_W     (Q_W),
        .Q       (Q),
        .D_W     (D_W),
        .NUM_FIX (NUM_FIX)
    ) u_fix (
        .resid   (st_q.b_res),
        .reduced (fixed_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.a_vld = in_valid;
        if (in_valid) begin
            st_d.a_val = in_value[D_W-1:0];
            st_d.a_mul = rom_mul;
        end
        st_d.b_vld = st_q.a_vld;
        if (st_q.a_vld) begin
            st_d.b_res = diff_lo;
        end
        st_d.o_vld = st_q.b_vld;
        if (st_q.b_vld) begin
            st_d.o_res = fixed_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.o_vld;
    assign out_residue = st_q.o_res;
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
    parameter int unsigned Q_W  = 8,
    parameter int unsigned Q    = 251,
    parameter int unsigned IN_W = Q_W + 9
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [IN_W-1:0] in_value,
    input logic            out_valid,
    input logic [Q_W-1:0]  out_residue
);
    localparam logic [IN_W-1:0] Q_EXT = IN_W'(Q);
    localparam logic [IN_W-1:0] LIMIT = IN_W'(512 * Q);

    // Cycles since reset, saturating at the pipeline depth.
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)                 seen_q <= 2'd0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> in_value < LIMIT);

    a_r2_below_q: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_residue < Q_W'(Q));

    a_r2_mod: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd3 && out_valid) |-> IN_W'(out_residue) == ($past(in_value, 3) % Q_EXT));

    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
        seen_q == 2'd3 |-> out_valid == $past(in_valid, 3));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd3 && !$past(in_valid, 3)) |-> out_residue == $past(out_residue));

    a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        seen_q != 2'd3 |-> (!out_valid && out_residue == '0));
endmodule

bind fine_reducer fr_checker #(
    .Q_W  (Q_W),
    .Q    (Q),
    .IN_W (IN_W)
) u_fr_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_value    (in_value),
    .out_valid   (out_valid),
    .out_residue (out_residue)
);

// File: tb/fine_reducer_bench.sv
module fine_reducer_bench;
    localparam int unsigned Q_W  = 8;
    localparam int unsigned Q    = 251;
    localparam int unsigned IN_W = Q_W + 9;
    localparam int unsigned TOP  = 512 * Q;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_value = '0;
    logic            ov_n, ov_w;
    logic [Q_W-1:0]  or_n, or_w;

    int total = 0;
    int bad   = 0;

    logic            hv [3];
    logic [IN_W-1:0] hd [3];
    logic [Q_W-1:0]  prev_n = '0;
    logic [Q_W-1:0]  prev_w = '0;

    always #4 clk = ~clk;

    fine_reducer #(.Q_W(Q_W), .Q(Q), .IDX_W(9)) u_fine_reducer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .out_valid(ov_n), .out_residue(or_n));

    fine_reducer #(.Q_W(Q_W), .Q(Q), .IDX_W(10)) u_fine_reducer_wide (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .out_valid(ov_w), .out_residue(or_w));

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs against the operand driven three falling edges ago,
    // then drive the next operand.
    task automatic step(input logic v, input int d, input string req);
        @(negedge clk);
        if (hv[2]) begin
            check(req, "valid narrow", int'(ov_n), 1);
            check(req, "residue narrow", int'(or_n), int'(hd[2]) % Q);
            check("R8", "valid wide", int'(ov_w), 1);
            check("R8", "residue wide", int'(or_w), int'(hd[2]) % Q);
        end else begin
            check("R4", "idle valid narrow", int'(ov_n), 0);
            check("R5", "hold narrow", int'(or_n), int'(prev_n));
            check("R4", "idle valid wide", int'(ov_w), 0);
            check("R5", "hold wide", int'(or_w), int'(prev_w));
        end
        prev_n = or_n;
        prev_w = or_w;
        hv[2] = hv[1]; hd[2] = hd[1];
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = IN_W'(d);
        in_valid = v;
        in_value = IN_W'(d);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0;
            hd[i] = '0;
        end
        repeat (4) @(negedge clk);
        check("R6", "reset valid", int'(ov_n) + int'(ov_w), 0);
        check("R6", "reset residue", int'(or_n) + int'(or_w), 0);
        rst = 1'b0;

        // R7: boundary operands back to back, then an idle gap
        step(1'b1, 0, "R7");
        step(1'b1, Q - 1, "R7");
        step(1'b1, Q, "R7");
        step(1'b1, TOP - 1, "R7");
        step(1'b0, 0, "R4");
        step(1'b0, 0, "R5");

        // R7: every exact multiple, with an idle cycle after every third
        for (int k = 0; k < 512; k++) begin
            step(1'b1, k * Q, "R7");
            if (k % 3 == 2) step(1'b0, 0, "R5");
        end

        // R2/R3: full back-to-back sweep of the input range
        for (int x = 0; x < int'(TOP); x++) begin
            step(1'b1, x, "R3");
        end

        // R2: random operands with random gaps
        for (int r = 0; r < 3000; r++) begin
            step(($urandom % 4) != 0, int'($urandom % TOP), "R2");
        end

        repeat (4) step(1'b0, 0, "R4");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule